// File: doc/BRIEF.md
# Prescaled Down-Counter Timer

A 16-bit countdown timer that sits on a simple APB-style peripheral port. Software writes a start value, picks a clock divider and an operating mode through a control word, and enables the counter. The counter then steps down by one on every prescaled tick. On the tick that brings it to zero it raises a level interrupt that stays high until software writes the acknowledge location.

There are two modes. In free-running mode the count passes through zero and continues from the all-ones value. In periodic mode the zero state is followed by a reload from the stored start value, so the interrupt repeats at a fixed rate. The live count can be read back at any time. A system with several timers instantiates this block several times.

Top module: `tick_down_timer`

## Requirements
- R1: After reset the start value, the live count, the control word and the interrupt output are all zero.
- R2: A write to offset 0x00 stores bits [15:0] as the start value and sets the live count to that value on the same clock edge. Reading offset 0x00 returns the start value, and reading offset 0x04 returns the live count, both zero-extended.
- R3: With enable set and divider code 00, the live count drops by one on every clock edge.
- R4: Divider code 01 gives one decrement every 16 clocks. Codes 10 and 11 each give one decrement every 256 clocks. The first decrement comes a full divider period after the enable write or the start-value write.
- R5: While enable is clear, the live count does not change.
- R6: The interrupt goes high on the edge where a tick takes the count from 1 to 0. It then stays high until it is acknowledged.
- R7: A write of any data to offset 0x0C lowers the interrupt. If a new zero event lands on the same edge as that write, the interrupt stays high.
- R8: In free-running mode (control bit 1 = 0), a tick at count 0 gives 0xFFFF.
- R9: In periodic mode (control bit 1 = 1), a tick at count 0 loads the stored start value.
- R10: A write to offset 0x04 has no effect. Reads never change the count.
- R11: A start-value write or a clear enable restarts the divider, so the next tick comes a full divider period later.
- R12: The control word at offset 0x08 is bit 0 enable, bit 1 mode, and bits [3:2] divider code. It reads back in those bits, and all higher bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe; a write commits when psel, penable and pwrite are all high |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (4) | Byte offset of the register |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data, valid in any cycle where psel is high; zero otherwise |
| irq | output | 1 | Level interrupt, held high until acknowledged |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a 4-bit middle divider and an 8-bit top divider. With these values a full divide-by-256 period fits easily in a short run. The wrap from zero to 0xFFFF can be observed within a few clocks of a small start value. Because a bus write takes two clock edges, the test can also line up an acknowledge write with a zero event on the same edge, which exercises the case where the new interrupt must win.

// File: rtl/tick_down_timer.sv
module tick_down_timer #(
  parameter int CNT_W     = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int MID_SHIFT = 4,
  parameter int TOP_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq
);

  localparam int PRE_W = TOP_SHIFT;
  localparam logic [ADDR_W-1:0] OFS_START = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_LIVE  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_ACK   = ADDR_W'(12);
  localparam logic [CNT_W-1:0]  ALL_ONES  = '1;
  localparam logic [CNT_W-1:0]  ONE       = CNT_W'(1);

  logic [CNT_W-1:0] start_q, count_q;
  logic [PRE_W-1:0] pre_q;
  logic [1:0]       div_q;
  logic             run_q, cyc_q;
  logic             wr, start_wr, ctrl_wr, ack_wr, tick, hit_zero;

  assign wr       = psel && penable && pwrite;
  assign start_wr = wr && (paddr == OFS_START);
  assign ctrl_wr  = wr && (paddr == OFS_CTRL);
  assign ack_wr   = wr && (paddr == OFS_ACK);

  always_comb begin
    case (div_q)
      2'b00:   tick = run_q;
      2'b01:   tick = run_q && (&pre_q[MID_SHIFT-1:0]);
      default: tick = run_q && (&pre_q);
    endcase
  end

  assign hit_zero = tick && !start_wr && (count_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cyc_q <= 1'b0;
      div_q <= 2'b00;
    end else if (ctrl_wr) begin
      run_q <= pwdata[0];
      cyc_q <= pwdata[1];
      div_q <= pwdata[3:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pre_q <= '0;
    else if (!run_q || start_wr) pre_q <= '0;
    else                         pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      count_q <= '0;
    end else if (start_wr) begin
      start_q <= pwdata[CNT_W-1:0];
      count_q <= pwdata[CNT_W-1:0];
    end else if (tick) begin
      if (count_q == '0) count_q <= cyc_q ? start_q : ALL_ONES;
      else               count_q <= count_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq <= 1'b0;
    else if (hit_zero) irq <= 1'b1;
    else if (ack_wr)   irq <= 1'b0;
  end

  always_comb begin
    prdata = '0;
    if (psel) begin
      case (paddr)
        OFS_START: prdata = DATA_W'(start_q);
        OFS_LIVE:  prdata = DATA_W'(count_q);
        OFS_CTRL:  prdata = DATA_W'({div_q, cyc_q, run_q});
        default:   prdata = '0;
      endcase
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> count_q == $past(pwdata[CNT_W-1:0]));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && div_q == 2'b00 && !start_wr && !ctrl_wr && count_q != '0
      |=> count_q == $past(count_q) - 1'b1);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !start_wr |=> $stable(count_q));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ack_wr |=> irq);

  p_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> count_q == '0);

  p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr && !hit_zero |=> !irq);

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !cyc_q && !start_wr && count_q == '0 |=> count_q == ALL_ONES);

  p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick && cyc_q && !start_wr && count_q == '0 |=> count_q == $past(start_q));

endmodule

// File: tb/tick_down_timer_test.sv
module tick_down_timer_test;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  // op: 0 write, 1 read-and-compare, 2 wait data cycles
  localparam vec_t TBL [NV] = '{
    '{2'd1, 4'h0, 32'h0,          32'h0,      8'd1},  // R1 start value
    '{2'd1, 4'h4, 32'h0,          32'h0,      8'd1},  // R1 live count
    '{2'd1, 4'h8, 32'h0,          32'h0,      8'd1},  // R1 control
    '{2'd0, 4'h0, 32'hABCD_1234,  32'h0,      8'd2},
    '{2'd1, 4'h0, 32'h0,          32'h1234,   8'd2},  // R2 start readback
    '{2'd1, 4'h4, 32'h0,          32'h1234,   8'd2},  // R2 live count set
    '{2'd0, 4'h4, 32'hBEEF,       32'h0,      8'd10},
    '{2'd1, 4'h4, 32'h0,          32'h1234,   8'd10}, // R10 write ignored
    '{2'd1, 4'h4, 32'h0,          32'h1234,   8'd10}, // R10 read no side effect
    '{2'd0, 4'h8, 32'hFFFF_FFF2,  32'h0,      8'd12},
    '{2'd1, 4'h8, 32'h0,          32'h2,      8'd12}, // R12 control bits only
    '{2'd0, 4'h8, 32'h0,          32'h0,      8'd5},
    '{2'd2, 4'h0, 32'd7,          32'h0,      8'd5},
    '{2'd1, 4'h4, 32'h0,          32'h1234,   8'd5}   // R5 held while off
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [3:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;
  int          checks = 0, errors = 0;
  logic        done = 1'b0;

  tick_down_timer uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    #1 d = prdata;
    psel = 1'b0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rdchk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic quiet_ack();
    wr(4'h8, 32'h0);
    wr(4'hC, 32'h0);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    logic [31:0] v;
    waitc(3);
    rst_n = 1'b1;
    waitc(1);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (TBL[i].op)
        2'd0: wr(TBL[i].addr, TBL[i].data);
        2'd1: begin
          rd(TBL[i].addr, v);
          checks++;
          if (v !== TBL[i].exp) begin
            errors++;
            $display("FAIL R%0d vector %0d: got %h expected %h", TBL[i].req, i, v, TBL[i].exp);
          end
        end
        default: waitc(int'(TBL[i].data));
      endcase
    end

    // R3 divide-by-1
    wr(4'h0, 32'd100);
    wr(4'h8, 32'h1);
    rdchk("R3 before", 4'h4, 32'd100);
    waitc(5);
    rdchk("R3 five steps", 4'h4, 32'd95);

    // R4 divide-by-16, then R11 restart on start-value write
    wr(4'h8, 32'h0);
    wr(4'h0, 32'd20);
    wr(4'h8, 32'h5);
    waitc(15);
    rdchk("R4 div16 not yet", 4'h4, 32'd20);
    waitc(1);
    rdchk("R4 div16 step", 4'h4, 32'd19);
    waitc(10);
    wr(4'h0, 32'd50);
    waitc(15);
    rdchk("R11 restart hold", 4'h4, 32'd50);
    waitc(1);
    rdchk("R11 restart step", 4'h4, 32'd49);

    // R4 divide-by-256 and reserved code
    wr(4'h8, 32'h0);
    wr(4'h0, 32'd7);
    wr(4'h8, 32'h9);
    waitc(255);
    rdchk("R4 div256 not yet", 4'h4, 32'd7);
    waitc(1);
    rdchk("R4 div256 step", 4'h4, 32'd6);
    wr(4'h8, 32'h0);
    wr(4'h0, 32'd7);
    wr(4'h8, 32'hD);
    waitc(255);
    rdchk("R4 code11 not yet", 4'h4, 32'd7);
    waitc(1);
    rdchk("R4 code11 step", 4'h4, 32'd6);

    // R6 and R9 periodic
    quiet_ack();
    chk("R7 ack idle", {31'b0, irq}, 32'h0);
    wr(4'h0, 32'd2);
    wr(4'h8, 32'h3);
    waitc(1);
    rdchk("R6 count one", 4'h4, 32'd1);
    chk("R6 low before zero", {31'b0, irq}, 32'h0);
    waitc(1);
    rdchk("R6 count zero", 4'h4, 32'd0);
    chk("R6 raised", {31'b0, irq}, 32'h1);
    waitc(1);
    rdchk("R9 reload", 4'h4, 32'd2);
    waitc(4);
    chk("R6 sticky", {31'b0, irq}, 32'h1);

    // R8 free-running wrap
    quiet_ack();
    wr(4'h0, 32'd2);
    wr(4'h8, 32'h1);
    waitc(3);
    rdchk("R8 wrap", 4'h4, 32'hFFFF);
    waitc(1);
    rdchk("R8 continue", 4'h4, 32'hFFFE);

    // R7 acknowledge versus same-edge zero event
    quiet_ack();
    wr(4'h0, 32'd4);
    wr(4'h8, 32'h1);
    waitc(2);
    rdchk("R7 setup", 4'h4, 32'd2);
    wr(4'hC, 32'h0);
    rdchk("R7 zero on ack edge", 4'h4, 32'd0);
    chk("R7 set wins", {31'b0, irq}, 32'h1);
    wr(4'h8, 32'h0);
    wr(4'hC, 32'h1234_5678);
    chk("R7 ack lowers", {31'b0, irq}, 32'h0);

    // R11 restart on disable
    wr(4'h0, 32'd30);
    wr(4'h8, 32'h5);
    waitc(9);
    wr(4'h8, 32'h4);
    wr(4'h8, 32'h5);
    waitc(15);
    rdchk("R11 disable restart hold", 4'h4, 32'd30);
    waitc(1);
    rdchk("R11 disable restart step", 4'h4, 32'd29);

    done = 1'b1;
    report();
  end
endmodule